// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block decides the ordering of two unsigned words and reports it as three flags: greater, equal and less. The words are cut into 4-bit slices. Each slice is handled by its own comparator stage, and the stages are linked in a chain from the least significant slice to the most significant one.

Each stage looks at its slice from the top bit down. The first bit position where the operands differ settles the slice's verdict. If every bit of the slice matches, the stage passes on whatever verdict arrives from the stage below it. The chain's own cascade inputs enter at the bottom slice. A designer ties them to the "equal" verdict for a standalone compare, or feeds them the flags of another comparator to extend the word further.

The parameter `STAGES` sets the operand width to `4*STAGES` bits. The block is purely combinational.

Top module: `mcmp_chain`

## Requirements
- R1: When both operands are equal and the cascade inputs are greater=0, equal=1, less=0, only `eq_o` is high.
- R2: When operand A is larger than operand B as an unsigned number, only `gt_o` is high, whatever the cascade inputs hold.
- R3: When operand A is smaller than operand B as an unsigned number, only `lt_o` is high, whatever the cascade inputs hold.
- R4: Whenever exactly one cascade input is high, exactly one of `gt_o`, `eq_o`, `lt_o` is high.
- R5: Inside a slice, the most significant differing bit position decides the slice's verdict, and all bit positions below it have no effect on the outputs.
- R6: When the full operands are equal, the three outputs equal the three cascade inputs bit for bit, even when the cascade inputs are not one-hot.
- R7: Slices are ordered so that bits 3:0 form slice 0. Each slice's verdict feeds the cascade of the next more significant slice, so a difference in a higher slice overrides any difference in a lower slice.
- R8: A slice whose operand bits differ produces a verdict from its own bits alone. Its incoming cascade value has no effect on that verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 4*STAGES | Operand A, unsigned |
| opb_i | input | 4*STAGES | Operand B, unsigned |
| casc_gt_i | input | 1 | Cascade verdict "greater" from a less significant comparator |
| casc_eq_i | input | 1 | Cascade verdict "equal" from a less significant comparator |
| casc_lt_i | input | 1 | Cascade verdict "less" from a less significant comparator |
| gt_o | output | 1 | A is greater than B |
| eq_o | output | 1 | A equals B, qualified by the cascade inputs |
| lt_o | output | 1 | A is less than B |

## Verification
The bound checker evaluates several properties whenever any input changes:
- the one-hot property of the outputs under legal cascade values;
- the pass-through of the cascade inputs on equal words;
- the agreement of the outputs with unsigned ordering;
- for every slice, that a differing slice's verdict depends only on its own bits.

Some behaviours only the bench's scenarios can show, because they need chosen operand pairs. These are:
- that lower bits are truly ignored once a higher bit differs;
- that non-one-hot cascade values survive unchanged;
- that the full 8-bit space and the 16-bit random vectors match the reference ordering.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

  localparam int SLICE_W = 4;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;

  // Equality of one bit pair
  function automatic logic bit_same(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

  // Scan a slice from its top bit down; first mismatch wins
  function automatic verdict_t slice_verdict(
    input logic [SLICE_W-1:0] same,
    input logic [SLICE_W-1:0] a_hi,
    input logic [SLICE_W-1:0] b_hi
  );
    verdict_t v;
    logic     above_same;
    v          = '0;
    above_same = 1'b1;
    for (int i = SLICE_W - 1; i >= 0; i--) begin
      v.gt       = v.gt | (above_same & a_hi[i]);
      v.lt       = v.lt | (above_same & b_hi[i]);
      above_same = above_same & same[i];
    end
    v.eq = above_same;
    return v;
  endfunction

  // A local tie lets the lower verdict through; otherwise the local one stands
  function automatic verdict_t merge_verdict(input verdict_t local_v,
                                             input verdict_t lower_v);
    verdict_t r;
    r.gt = local_v.gt | (local_v.eq & lower_v.gt);
    r.lt = local_v.lt | (local_v.eq & lower_v.lt);
    r.eq = local_v.eq & lower_v.eq;
    return r;
  endfunction

endpackage

// File: rtl/mcmp_bitcell.sv
module mcmp_bitcell (
  input  logic a_i,
  input  logic b_i,
  output logic same_o,
  output logic a_hi_o,
  output logic b_hi_o
);
  import mcmp_pkg::*;

  assign same_o = bit_same(a_i, b_i);
  assign a_hi_o = a_i & ~b_i;
  assign b_hi_o = ~a_i & b_i;

endmodule

// File: rtl/mcmp_slice.sv
module mcmp_slice
  import mcmp_pkg::*;
(
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  logic               low_gt_i,
  input  logic               low_eq_i,
  input  logic               low_lt_i,
  output logic               loc_eq_o,
  output logic               gt_o,
  output logic               eq_o,
  output logic               lt_o
);

  logic [SLICE_W-1:0] same;
  logic [SLICE_W-1:0] a_hi;
  logic [SLICE_W-1:0] b_hi;
  verdict_t           local_v;
  verdict_t           lower_v;
  verdict_t           out_v;

  for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
    mcmp_bitcell u_cell (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .same_o(same[i]),
      .a_hi_o(a_hi[i]),
      .b_hi_o(b_hi[i])
    );
  end

  always_comb begin
    local_v = slice_verdict(same, a_hi, b_hi);
    lower_v = '{gt: low_gt_i, eq: low_eq_i, lt: low_lt_i};
    out_v   = merge_verdict(local_v, lower_v);
  end

  assign loc_eq_o = local_v.eq;
  assign gt_o     = out_v.gt;
  assign eq_o     = out_v.eq;
  assign lt_o     = out_v.lt;

endmodule

// File: rtl/mcmp_chain.sv
module mcmp_chain
  import mcmp_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic [SLICE_W*STAGES-1:0] opa_i,
  input  logic [SLICE_W*STAGES-1:0] opb_i,
  input  logic                      casc_gt_i,
  input  logic                      casc_eq_i,
  input  logic                      casc_lt_i,
  output logic                      gt_o,
  output logic                      eq_o,
  output logic                      lt_o
);

  localparam int WIDTH = SLICE_W * STAGES;

  // Link k carries the verdict entering slice k; link STAGES is the result
  logic [STAGES:0]   chain_gt;
  logic [STAGES:0]   chain_eq;
  logic [STAGES:0]   chain_lt;
  logic [STAGES-1:0] slice_tie;

  assign chain_gt[0] = casc_gt_i;
  assign chain_eq[0] = casc_eq_i;
  assign chain_lt[0] = casc_lt_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_slice
    mcmp_slice u_slice (
      .a_i     (opa_i[k*SLICE_W +: SLICE_W]),
      .b_i     (opb_i[k*SLICE_W +: SLICE_W]),
      .low_gt_i(chain_gt[k]),
      .low_eq_i(chain_eq[k]),
      .low_lt_i(chain_lt[k]),
      .loc_eq_o(slice_tie[k]),
      .gt_o    (chain_gt[k+1]),
      .eq_o    (chain_eq[k+1]),
      .lt_o    (chain_lt[k+1])
    );
  end

  assign gt_o = chain_gt[STAGES];
  assign eq_o = chain_eq[STAGES];
  assign lt_o = chain_lt[STAGES];

endmodule

// File: rtl/mcmp_chain_chk.sv
module mcmp_chain_chk #(
  parameter int STAGES = 4
) (
  input logic [4*STAGES-1:0] opa_i,
  input logic [4*STAGES-1:0] opb_i,
  input logic                casc_gt_i,
  input logic                casc_eq_i,
  input logic                casc_lt_i,
  input logic                gt_o,
  input logic                eq_o,
  input logic                lt_o,
  input logic [STAGES:0]     chain_gt,
  input logic [STAGES:0]     chain_lt,
  input logic [STAGES-1:0]   slice_tie
);

  always_comb begin
    if ($onehot({casc_gt_i, casc_eq_i, casc_lt_i})) begin
      // R4
      one_hot_out_chk: assert ($onehot({gt_o, eq_o, lt_o}))
        else $error("R4 outputs not one-hot");
    end
    if (opa_i == opb_i) begin
      // R6
      equal_pass_chk: assert ({gt_o, eq_o, lt_o} == {casc_gt_i, casc_eq_i, casc_lt_i})
        else $error("R6 cascade not passed through");
    end
    if (opa_i > opb_i) begin
      // R2
      greater_chk: assert (gt_o && !eq_o && !lt_o)
        else $error("R2 greater not reported");
    end
    if (opa_i < opb_i) begin
      // R3
      less_chk: assert (lt_o && !eq_o && !gt_o)
        else $error("R3 less not reported");
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_slice_chk
    always_comb begin
      if (opa_i[k*4 +: 4] != opb_i[k*4 +: 4]) begin
        // R8
        slice_own_chk: assert (!slice_tie[k] &&
                               chain_gt[k+1] == (opa_i[k*4 +: 4] > opb_i[k*4 +: 4]) &&
                               chain_lt[k+1] == (opa_i[k*4 +: 4] < opb_i[k*4 +: 4]))
          else $error("R8 slice %0d verdict depends on cascade", k);
      end
    end
  end

endmodule

bind mcmp_chain mcmp_chain_chk #(.STAGES(STAGES)) u_chk (
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .casc_gt_i(casc_gt_i),
  .casc_eq_i(casc_eq_i),
  .casc_lt_i(casc_lt_i),
  .gt_o     (gt_o),
  .eq_o     (eq_o),
  .lt_o     (lt_o),
  .chain_gt (chain_gt),
  .chain_lt (chain_lt),
  .slice_tie(slice_tie)
);

// File: tb/mcmp_chain_test.sv
`timescale 1ns/1ps
module mcmp_chain_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [15:0] a16, b16;
  logic        cg, ce, cl;
  logic        g16, e16, l16;
  logic [7:0]  a8, b8;
  logic        g8, e8, l8;

  mcmp_chain #(.STAGES(4)) uut (
    .opa_i(a16), .opb_i(b16),
    .casc_gt_i(cg), .casc_eq_i(ce), .casc_lt_i(cl),
    .gt_o(g16), .eq_o(e16), .lt_o(l16)
  );

  mcmp_chain #(.STAGES(2)) uut8 (
    .opa_i(a8), .opb_i(b8),
    .casc_gt_i(1'b0), .casc_eq_i(1'b1), .casc_lt_i(1'b0),
    .gt_o(g8), .eq_o(e8), .lt_o(l8)
  );

  // Reference: ordering of whole words, cascade only on a full tie
  function automatic logic [2:0] expect_rel(input logic [15:0] a, input logic [15:0] b,
                                            input logic [2:0] casc);
    if (a > b) return 3'b100;
    if (a < b) return 3'b001;
    return casc;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (a=%h b=%h)", req, act, exp, a16, b16);
    end
  endtask

  task automatic apply16(input logic [15:0] a, input logic [15:0] b, input logic [2:0] casc,
                         input string req);
    a16 = a; b16 = b; {cg, ce, cl} = casc;
    #2;
    check(req, {g16, e16, l16}, expect_rel(a, b, casc));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 150000) begin
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    a16 = '0; b16 = '0; {cg, ce, cl} = 3'b010; a8 = '0; b8 = '0;
    #2;
    // R1 idle/all-zero state reports equality
    check("R1", {g16, e16, l16}, 3'b010);

    apply16(16'hBEEF, 16'hBEEF, 3'b010, "R1");
    apply16(16'h8000, 16'h7FFF, 3'b010, "R2");
    apply16(16'h0000, 16'hFFFF, 3'b010, "R3");
    // R2 / R3 ignore cascade when words differ
    apply16(16'h1234, 16'h1233, 3'b001, "R2");
    apply16(16'h1233, 16'h1234, 3'b100, "R3");
    // R5: top differing bit inside a slice decides, lower bits opposite
    apply16(16'h0008, 16'h0007, 3'b010, "R5");
    apply16(16'h0400, 16'h0BFF, 3'b010, "R5");
    // R7: higher slice overrides lower slice
    apply16(16'h1000, 16'h0FFF, 3'b010, "R7");
    apply16(16'h00F0, 16'h010F, 3'b010, "R7");
    // R8: differing low slice ignores cascade
    apply16(16'h0005, 16'h0003, 3'b001, "R8");
    apply16(16'h0003, 16'h0005, 3'b100, "R8");
    // R6: every cascade pattern passes on equal words
    for (int c = 0; c < 8; c++) begin
      apply16(16'h5A5A, 16'h5A5A, c[2:0], "R6");
    end
    // R4: legal cascade values over random words
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] cs;
      case ($urandom_range(2))
        0: cs = 3'b100;
        1: cs = 3'b010;
        default: cs = 3'b001;
      endcase
      if ($urandom_range(3) == 0) begin
        logic [15:0] r;
        r = 16'($urandom);
        apply16(r, r ^ (16'h1 << $urandom_range(15)), cs, "R4");
      end else begin
        apply16(16'($urandom), 16'($urandom), cs, "R4");
      end
    end
    // R7: exhaustive two-slice chain
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        a8 = a[7:0]; b8 = b[7:0];
        #2;
        n_run++;
        if ({g8, e8, l8} !== {a > b, a == b, a < b}) begin
          n_fail++;
          $display("FAIL R7: got %b expected %b (a=%h b=%h)", {g8, e8, l8},
                   {a > b, a == b, a < b}, a8, b8);
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule